// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load captures a full external address. The two lowest bits of that address become the start point of the burst. Each advance then steps the two low bits to the next beat. The upper bits are held unchanged for the whole burst.

Two beat orders are available, chosen by a static order input. In linear order the low bits count up from the start point, modulo four. In interleaved order each beat's low bits are the start bits XORed with the beat index. In both orders the fourth advance brings the low bits back to the start point.

A clock enable gates every state change, so the sequencer can be paused for any number of cycles. The order input is not registered. It acts on the output continuously.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, all state clears, and `addr_out` then reads 0.
- R2: A rising edge with `ce`=1 and `load`=1 captures `addr_in`. From then on `addr_out` equals the captured address, in either order. This sets the beat index to 0.
- R3: With `order_sel`=0 (linear), beat k after a load has low bits `(start + k) mod 4`. Example: start 01 gives 01, 10, 11, 00.
- R4: With `order_sel`=1 (interleaved), beat k has low bits `start XOR k`. Example: start 10 gives 10, 11, 00, 01.
- R5: After four advances the low bits return to the loaded start value. Further advances repeat the same cycle.
- R6: The beat advances only on a rising edge where `ce`=1 and `adv`=1. With `ce`=0, or with `adv`=0 and `load`=0, `addr_out` is unchanged.
- R7: With `ce`=0, `load` is ignored, and `addr_out` keeps its previous value.
- R8: Bits `[ADDR_W-1:2]` of `addr_out` stay constant across advances. They change only on a load.
- R9: When `load` and `adv` are both high with `ce`=1, the load wins. `addr_out` becomes `addr_in`, at beat 0.
- R10: `order_sel` acts with no register in its path. A change of `order_sel` shows at `addr_out` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high; gates load and advance |
| load | input | 1 | Capture `addr_in` and restart the burst at beat 0 |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
The assertions are checked on every cycle. They cover:
- the beat index holds when no enabled load or advance occurs;
- each enabled advance steps the index by one, modulo four;
- an enabled load clears the index, even with advance also high;
- the upper bits hold between loads;
- a load makes the output equal the captured address;
- beat zero maps to the start bits in both orders.

Some behaviours can be shown only by the bench's scenarios, which compare the output with its own model. These are:
- the actual beat orders, linear and interleaved;
- the return to the start after four beats;
- that a load is ignored while the clock enable is low;
- the combinational effect of the order input.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  // Load outranks advance; the counter wraps naturally at 2**BEAT_W.
  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
    end else if (ce) begin
      if (load)     beat <= '0;
      else if (adv) beat <= beat + ONE;
    end
  end

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !(ce && (load || adv)) |=> $stable(beat));

  p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && adv && !load) |=> (beat == $past(beat) + ONE));

  p_load_first_r9: assert property (@(posedge clk) disable iff (rst)
    (ce && load) |=> (beat == '0));

endmodule

// File: rtl/bseq_addr_hold.sv
module bseq_addr_hold #(
  parameter int UP_W  = 16,
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             load,
  input  logic [UP_W-1:0]  up_in,
  input  logic [LOW_W-1:0] low_in,
  output logic [UP_W-1:0]  up_q,
  output logic [LOW_W-1:0] start_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= '0;
      start_q <= '0;
    end else if (ce && load) begin
      up_q    <= up_in;
      start_q <= low_in;
    end
  end

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(ce && load) |=> $stable(up_q));

  p_start_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(ce && load) |=> $stable(start_q));

endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
  import burst_seq_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] start,
  input  logic [LOW_W-1:0] beat,
  input  order_e           order,
  output logic [LOW_W-1:0] low
);

  logic [LOW_W-1:0] xor_low;
  logic [LOW_W-1:0] add_low;

  // Interleaved order: each bit is flipped by the matching beat-index bit.
  for (genvar i = 0; i < LOW_W; i++) begin : g_xor
    assign xor_low[i] = start[i] ^ beat[i];
  end

  // Linear order: modulo-2**LOW_W sum.
  assign add_low = start + beat;

  always_comb begin
    case (order)
      ORD_INTERLEAVE: low = xor_low;
      default:        low = add_low;
    endcase
  end

  always_comb begin
    if (beat == '0) begin
      a_first_beat_r3: assert (low == start);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int LOW_W = BEAT_W;
  localparam int UP_W  = ADDR_W - LOW_W;

  logic [LOW_W-1:0] beat;
  logic [LOW_W-1:0] start_q;
  logic [LOW_W-1:0] low;
  logic [UP_W-1:0]  up_q;
  order_e           order;

  assign order = order_e'(order_sel);

  bseq_beat_ctr #(.BEAT_W(LOW_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .ce   (ce),
    .load (load),
    .adv  (adv),
    .beat (beat)
  );

  bseq_addr_hold #(.UP_W(UP_W), .LOW_W(LOW_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .load    (load),
    .up_in   (addr_in[ADDR_W-1:LOW_W]),
    .low_in  (addr_in[LOW_W-1:0]),
    .up_q    (up_q),
    .start_q (start_q)
  );

  bseq_low_map #(.LOW_W(LOW_W)) u_map (
    .start (start_q),
    .beat  (beat),
    .order (order),
    .low   (low)
  );

  assign addr_out = {up_q, low};

  p_load_visible_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && load) |=> (addr_out == $past(addr_in)));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst, ce, load, adv, order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 1'b0;

  logic [AW-3:0] m_up;
  logic [1:0]    m_start, m_beat;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .load(load), .adv(adv),
    .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-3:0] up, logic [1:0] st,
                                                logic [1:0] bt, logic md);
    logic [1:0] lo;
    lo = md ? (st ^ bt) : 2'(st + bt);
    return {up, lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic l, logic a, logic m, logic [AW-1:0] ad, string req);
    @(negedge clk);
    ce = c; load = l; adv = a; order_sel = m; addr_in = ad;
    @(posedge clk);
    if (c) begin
      if (l) begin
        m_up = ad[AW-1:2]; m_start = ad[1:0]; m_beat = 2'd0;
      end else if (a) begin
        m_beat = m_beat + 2'd1;
      end
    end
    #2;
    check(req, addr_out, expect_addr(m_up, m_start, m_beat, m));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    rst = 1'b1; ce = 1'b0; load = 1'b0; adv = 1'b0; order_sel = 1'b0; addr_in = '0;
    m_up = '0; m_start = '0; m_beat = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", addr_out, '0);
    @(negedge clk);
    rst = 1'b0;

    // Linear burst from start 10: 10, 11, 00, 01, then back to 10
    step(1, 1, 0, 0, 18'h2A5F6, "R2 load linear");
    step(1, 0, 1, 0, 18'h00000, "R3 linear beat1");
    step(1, 0, 1, 0, 18'h00000, "R3 linear beat2");
    step(1, 0, 1, 0, 18'h3FFFF, "R3 R8 linear beat3 upper held");
    step(1, 0, 1, 0, 18'h00000, "R5 linear wrap");
    // Linear burst from start 01: 01, 10, 11, 00
    step(1, 1, 0, 0, 18'h15555, "R2 load start 01");
    step(1, 0, 1, 0, 18'h00000, "R3 linear 01->10");
    step(1, 0, 1, 0, 18'h00000, "R3 linear 10->11");
    step(1, 0, 1, 0, 18'h00000, "R3 linear 11->00");

    // Interleaved burst from start 10: 10, 11, 00, 01, then back to 10
    step(1, 1, 0, 1, 18'h0C3A2, "R2 load interleaved");
    step(1, 0, 1, 1, 18'h00000, "R4 interleave beat1");
    step(1, 0, 1, 1, 18'h00000, "R4 interleave beat2");
    step(1, 0, 1, 1, 18'h00000, "R4 R8 interleave beat3");
    step(1, 0, 1, 1, 18'h00000, "R5 interleave wrap");

    // Enable low: advance and load have no effect
    step(0, 0, 1, 1, 18'h00000, "R6 ce low advance");
    step(0, 1, 0, 1, 18'h3FFFD, "R7 ce low load ignored");
    step(1, 0, 0, 1, 18'h3FFFD, "R6 no advance");

    // Load and advance together: the load wins
    step(1, 1, 1, 0, 18'h12347, "R9 load over advance");
    step(1, 0, 1, 0, 18'h00000, "R3 after priority load");

    // Order input acts without a clock edge
    @(negedge clk);
    ce = 1'b0; order_sel = 1'b1;
    #1;
    check("R10 order flip to interleave", addr_out, expect_addr(m_up, m_start, m_beat, 1'b1));
    order_sel = 1'b0;
    #1;
    check("R10 order flip to linear", addr_out, expect_addr(m_up, m_start, m_beat, 1'b0));

    // Random traffic; the order is held for stretches as a static strap would be
    for (int i = 0; i < 600; i++) begin
      logic md;
      md = (i / 150) % 2 == 1;
      step(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 3) != 0, md,
           AW'($urandom), "R3 R4 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule